// File: doc/BRIEF.md
# Rotate, Shift and Bit-Test Unit

This unit carries out the single-operand bit-manipulation class of an 8-bit processor datapath. It accepts one byte, the accumulator and the current flag byte. From a 2-bit group code and a 3-bit selector it produces a rotated or shifted byte, a bit-test flag update, or a byte with one bit cleared or set. Two side inputs choose the short accumulator rotates, which leave the sign, zero and parity flags alone, or the nibble rotates, which move 4-bit digits between the accumulator and a memory byte.

The surrounding core pulses `start` with the operation fields and operands valid. One clock later the unit presents the result byte, the new accumulator and the new flags, and raises `done` for a single cycle. The outputs then hold until the next start. Fetching, prefix decoding and the memory cycles stay with the core.

The flag byte layout is, from bit 7 down to bit 0: S (sign), Z (zero), Y (copy of bit 5), H (half carry), X (copy of bit 3), P/V (parity/overflow), N (subtract), C (carry). Parity is 1 when the byte holds an even number of ones.

Top module: `rotbit_unit`

## Requirements
- R1: Inputs are captured on a clock edge where `start` is 1. `result`, `acc_out` and `flg_out` change only on such an edge and hold otherwise. `done` is 1 exactly in the cycle after a start. After reset, `done` and all outputs are 0.
- R2: With `grp`=00, these `sel` values rotate `opnd`: 000 rotates left, with bit 7 going to bit 0 and to C. 001 rotates right, with bit 0 going to bit 7 and to C. 010 rotates left through carry, with old C entering bit 0 and bit 7 leaving to C. 011 rotates right through carry, with old C entering bit 7 and bit 0 leaving to C.
- R3: With `grp`=00, these `sel` values shift `opnd`: 100 shifts left and inserts 0. 101 shifts right and keeps bit 7. 110 shifts left and inserts 1. 111 shifts right and inserts 0. In every case the bit that leaves goes to C.
- R4: For `grp`=00, the flags are taken from the result: S from bit 7, Z when the result is 0, Y and X from result bits 5 and 3, and P/V from even parity. H and N are 0. `acc_out` equals `acc_in`.
- R5: With `fast_rot`=1, `sel[1:0]` picks one of the four R2 rotates and applies it to `acc_in`. The rotated byte appears on both `result` and `acc_out`. Y, X and C follow the rotate, H and N are 0, and S, Z and P/V are copied from `flg_in`.
- R6: With `nib_rot`=1 and `sel[0]`=0, the unit performs a left nibble rotate. From A=pq and memory=rs it gives `acc_out`=pr and `result`=sq.
- R7: With `nib_rot`=1 and `sel[0]`=1, the unit performs a right nibble rotate, giving `acc_out`=ps and `result`=qr. For both nibble rotates, S, Z, Y, X and P/V come from the new A, H and N are 0, and C is kept.
- R8: With `grp`=01, the unit tests bit `sel` of `opnd`. Z is set when that bit is 0, P/V equals Z, H is 1, N is 0 and C is kept. `result` equals `opnd`.
- R9: For a bit test, S is 1 only when `sel`=111 and `opnd[7]`=1. Y and X copy `opnd` bits 5 and 3.
- R10: With `grp`=10, bit `sel` of `opnd` is cleared. With `grp`=11, it is set. For both groups `flg_out` equals `flg_in` and `acc_out` equals `acc_in`.
- R11: `nib_rot` takes priority over `fast_rot`, and `fast_rot` takes priority over `grp`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launches an operation |
| grp | input | 2 | Group: 00 rotate/shift, 01 test, 10 clear, 11 set |
| sel | input | 3 | Rotate/shift kind or bit index |
| opnd | input | 8 | Operand byte or memory byte |
| acc_in | input | 8 | Accumulator |
| flg_in | input | 8 | Current flags |
| fast_rot | input | 1 | Selects the short accumulator rotate |
| nib_rot | input | 1 | Selects a nibble rotate |
| done | output | 1 | One-cycle completion strobe |
| result | output | 8 | Result byte |
| acc_out | output | 8 | New accumulator |
| flg_out | output | 8 | New flags |

## Verification
The shift and rotate kinds are run on bytes whose end bits differ (0x81, 0x80, 0x01, 0x00), each with carry in both states. This separates circular rotates from rotates through carry, and shows which fill bit each shift inserts. Parity and zero are tried on results with odd and even counts of ones. Bit tests sweep every index over operands with the tested bit both set and clear, so the bit-7-only sign rule and the copied bits 5 and 3 are each exposed. Nibble rotates use four distinct digits so that any misrouted nibble shows. Conflicting selectors confirm the priority order.

// File: rtl/rotbit_unit.sv
module rotbit_unit (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] grp,
  input  logic [2:0] sel,
  input  logic [7:0] opnd,
  input  logic [7:0] acc_in,
  input  logic [7:0] flg_in,
  input  logic       fast_rot,
  input  logic       nib_rot,
  output logic       done,
  output logic [7:0] result,
  output logic [7:0] acc_out,
  output logic [7:0] flg_out
);
  localparam int SF = 7, ZF = 6, YF = 5, HF = 4, XF = 3, PF = 2, NF = 1, CF = 0;

  logic [7:0] src, sh_r, bmask;
  logic [2:0] kind;
  logic       cin, sh_c;
  logic [7:0] n_res, n_acc, n_flg;

  assign cin   = flg_in[CF];
  assign src   = fast_rot ? acc_in : opnd;
  assign kind  = fast_rot ? {1'b0, sel[1:0]} : sel;
  assign bmask = 8'b1 << sel;

  always_comb begin
    case (kind)
      3'b000:  {sh_c, sh_r} = {src[7], src[6:0], src[7]};
      3'b001:  {sh_c, sh_r} = {src[0], src[0], src[7:1]};
      3'b010:  {sh_c, sh_r} = {src[7], src[6:0], cin};
      3'b011:  {sh_c, sh_r} = {src[0], cin, src[7:1]};
      3'b100:  {sh_c, sh_r} = {src[7], src[6:0], 1'b0};
      3'b101:  {sh_c, sh_r} = {src[0], src[7], src[7:1]};
      3'b110:  {sh_c, sh_r} = {src[7], src[6:0], 1'b1};
      default: {sh_c, sh_r} = {src[0], 1'b0, src[7:1]};
    endcase
  end

  always_comb begin
    n_res = opnd;
    n_acc = acc_in;
    n_flg = flg_in;
    if (nib_rot) begin
      if (!sel[0]) begin
        n_acc = {acc_in[7:4], opnd[7:4]};
        n_res = {opnd[3:0], acc_in[3:0]};
      end else begin
        n_acc = {acc_in[7:4], opnd[3:0]};
        n_res = {acc_in[3:0], opnd[7:4]};
      end
      n_flg[SF] = n_acc[7];
      n_flg[ZF] = (n_acc == 8'h00);
      n_flg[YF] = n_acc[5];
      n_flg[HF] = 1'b0;
      n_flg[XF] = n_acc[3];
      n_flg[PF] = ~^n_acc;
      n_flg[NF] = 1'b0;
    end else if (fast_rot) begin
      n_res     = sh_r;
      n_acc     = sh_r;
      n_flg[YF] = sh_r[5];
      n_flg[HF] = 1'b0;
      n_flg[XF] = sh_r[3];
      n_flg[NF] = 1'b0;
      n_flg[CF] = sh_c;
    end else begin
      case (grp)
        2'b00: begin
          n_res = sh_r;
          n_flg = {sh_r[7], sh_r == 8'h00, sh_r[5], 1'b0, sh_r[3], ~^sh_r, 1'b0, sh_c};
        end
        2'b01: begin
          n_flg[SF] = (sel == 3'd7) && opnd[7];
          n_flg[ZF] = ~|(opnd & bmask);
          n_flg[YF] = opnd[5];
          n_flg[HF] = 1'b1;
          n_flg[XF] = opnd[3];
          n_flg[PF] = ~|(opnd & bmask);
          n_flg[NF] = 1'b0;
        end
        2'b10:   n_res = opnd & ~bmask;
        default: n_res = opnd | bmask;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done    <= 1'b0;
      result  <= '0;
      acc_out <= '0;
      flg_out <= '0;
    end else begin
      done <= start;
      if (start) begin
        result  <= n_res;
        acc_out <= n_acc;
        flg_out <= n_flg;
      end
    end
  end
endmodule

module rotbit_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic [1:0] grp,
  input logic [7:0] opnd,
  input logic [7:0] acc_in,
  input logic [7:0] flg_in,
  input logic       fast_rot,
  input logic       nib_rot,
  input logic       done,
  input logic [7:0] result,
  input logic [7:0] acc_out,
  input logic [7:0] flg_out
);
  AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done); // R1
  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done); // R1
  AST_OUTPUTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(result) && $stable(acc_out) && $stable(flg_out))); // R1
  AST_SHIFT_HN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !nib_rot && !fast_rot && grp == 2'b00) |=> (!flg_out[4] && !flg_out[1] && acc_out == $past(acc_in))); // R4
  AST_FAST_KEEPS_SZP: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !nib_rot && fast_rot) |=> (flg_out[7:6] == $past(flg_in[7:6]) && flg_out[2] == $past(flg_in[2]) && result == acc_out)); // R5
  AST_NIBBLE_KEEPS_C: assert property (@(posedge clk) disable iff (!rst_n)
    (start && nib_rot) |=> (flg_out[0] == $past(flg_in[0]) && !flg_out[4] && !flg_out[1])); // R7
  AST_TEST_HN_C: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !nib_rot && !fast_rot && grp == 2'b01) |=> (flg_out[4] && !flg_out[1] && flg_out[0] == $past(flg_in[0]) && flg_out[2] == flg_out[6] && result == $past(opnd))); // R8
  AST_CLRSET_FLAGS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !nib_rot && !fast_rot && grp[1]) |=> (flg_out == $past(flg_in) && acc_out == $past(acc_in))); // R10
endmodule

bind rotbit_unit rotbit_unit_chk i_rotbit_unit_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .grp(grp), .opnd(opnd),
  .acc_in(acc_in), .flg_in(flg_in), .fast_rot(fast_rot), .nib_rot(nib_rot),
  .done(done), .result(result), .acc_out(acc_out), .flg_out(flg_out));

// File: tb/test_rotbit_unit.sv
`timescale 1ns/1ps
module test_rotbit_unit;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, fast_rot = 1'b0, nib_rot = 1'b0;
  logic [1:0] grp = '0;
  logic [2:0] sel = '0;
  logic [7:0] opnd = '0, acc_in = '0, flg_in = '0;
  logic done;
  logic [7:0] result, acc_out, flg_out;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  rotbit_unit i_rotbit_unit (.clk(clk), .rst_n(rst_n), .start(start), .grp(grp), .sel(sel),
    .opnd(opnd), .acc_in(acc_in), .flg_in(flg_in), .fast_rot(fast_rot), .nib_rot(nib_rot),
    .done(done), .result(result), .acc_out(acc_out), .flg_out(flg_out));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic logic par_even(input logic [7:0] v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += v[i];
    return (n % 2) == 0;
  endfunction

  function automatic logic [7:0] full_flags(input logic [7:0] r, input logic c);
    return {r[7], r == 0, r[5], 1'b0, r[3], par_even(r), 1'b0, c};
  endfunction

  task automatic issue(input logic [1:0] g, input logic [2:0] s, input logic [7:0] o,
                       input logic [7:0] a, input logic [7:0] f, input logic fa, input logic nb);
    @(negedge clk);
    grp = g; sel = s; opnd = o; acc_in = a; flg_in = f; fast_rot = fa; nib_rot = nb; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 reset done", {7'b0, done}, 8'h00);
    chk("R1 reset result", result, 8'h00);
    chk("R1 reset flags", flg_out, 8'h00);
  endtask

  task automatic t_timing;
    issue(2'b00, 3'b000, 8'h81, 8'h5A, 8'h00, 1'b0, 1'b0);
    chk("R1 done strobe", {7'b0, done}, 8'h01);
    chk("R1 result ready", result, 8'h03);
    opnd = 8'hFF; acc_in = 8'h11; flg_in = 8'hFF;
    @(negedge clk);
    chk("R1 done drops", {7'b0, done}, 8'h00);
    chk("R1 result holds", result, 8'h03);
    chk("R1 flags hold", flg_out, full_flags(8'h03, 1'b1));
  endtask

  task automatic t_rotates;
    logic [7:0] vals [4] = '{8'h81, 8'h80, 8'h01, 8'h00};
    for (int v = 0; v < 4; v++)
      for (int c = 0; c < 2; c++) begin
        logic [7:0] o, e; logic ec;
        o = vals[v];
        issue(2'b00, 3'b000, o, 8'h33, {7'b0, c[0]}, 1'b0, 1'b0);
        e = {o[6:0], o[7]}; ec = o[7];
        chk("R2 rlc result", result, e); chk("R4 rlc flags", flg_out, full_flags(e, ec));
        chk("R4 acc unchanged", acc_out, 8'h33);
        issue(2'b00, 3'b001, o, 8'h33, {7'b0, c[0]}, 1'b0, 1'b0);
        e = {o[0], o[7:1]}; ec = o[0];
        chk("R2 rrc result", result, e); chk("R4 rrc flags", flg_out, full_flags(e, ec));
        issue(2'b00, 3'b010, o, 8'h33, {7'b0, c[0]}, 1'b0, 1'b0);
        e = {o[6:0], c[0]}; ec = o[7];
        chk("R2 rl result", result, e); chk("R4 rl flags", flg_out, full_flags(e, ec));
        issue(2'b00, 3'b011, o, 8'h33, {7'b0, c[0]}, 1'b0, 1'b0);
        e = {c[0], o[7:1]}; ec = o[0];
        chk("R2 rr result", result, e); chk("R4 rr flags", flg_out, full_flags(e, ec));
      end
  endtask

  task automatic t_shifts;
    logic [7:0] vals [4] = '{8'h81, 8'hA8, 8'h01, 8'h00};
    for (int v = 0; v < 4; v++) begin
      logic [7:0] o, e;
      o = vals[v];
      issue(2'b00, 3'b100, o, 8'h00, 8'h01, 1'b0, 1'b0);
      e = o << 1;
      chk("R3 sla result", result, e); chk("R4 sla flags", flg_out, full_flags(e, o[7]));
      issue(2'b00, 3'b101, o, 8'h00, 8'h00, 1'b0, 1'b0);
      e = {o[7], o[7:1]};
      chk("R3 sra result", result, e); chk("R4 sra flags", flg_out, full_flags(e, o[0]));
      issue(2'b00, 3'b110, o, 8'h00, 8'h00, 1'b0, 1'b0);
      e = (o << 1) | 8'h01;
      chk("R3 sl1 result", result, e); chk("R4 sl1 flags", flg_out, full_flags(e, o[7]));
      issue(2'b00, 3'b111, o, 8'h00, 8'h01, 1'b0, 1'b0);
      e = o >> 1;
      chk("R3 srl result", result, e); chk("R4 srl flags", flg_out, full_flags(e, o[0]));
    end
  endtask

  task automatic t_fast;
    logic [7:0] a, e, f;
    a = 8'h81; f = 8'hC4;
    for (int k = 0; k < 4; k++) begin
      logic c;
      case (k)
        0: begin e = {a[6:0], a[7]}; c = a[7]; end
        1: begin e = {a[0], a[7:1]}; c = a[0]; end
        2: begin e = {a[6:0], f[0]}; c = a[7]; end
        default: begin e = {f[0], a[7:1]}; c = a[0]; end
      endcase
      issue(2'b00, {1'b1, 2'(k)}, 8'hFF, a, f, 1'b1, 1'b0);
      chk("R5 fast result", result, e);
      chk("R5 fast acc", acc_out, e);
      chk("R5 fast flags", flg_out, {f[7:6], e[5], 1'b0, e[3], f[2], 1'b0, c});
    end
  endtask

  task automatic t_nibble;
    issue(2'b00, 3'b000, 8'h9C, 8'h2B, 8'h13, 1'b0, 1'b1);
    chk("R6 rld acc", acc_out, 8'h29);
    chk("R6 rld mem", result, 8'hCB);
    chk("R7 rld flags", flg_out, {1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1});
    issue(2'b00, 3'b001, 8'h9C, 8'h2B, 8'h12, 1'b0, 1'b1);
    chk("R7 rrd acc", acc_out, 8'h2C);
    chk("R7 rrd mem", result, 8'hB9);
    chk("R7 rrd flags", flg_out, {1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0});
    issue(2'b00, 3'b001, 8'h30, 8'h05, 8'h00, 1'b0, 1'b1);
    chk("R7 rrd zero acc", acc_out, 8'h00);
    chk("R7 rrd zero flags", flg_out, 8'h44);
  endtask

  task automatic t_bittest;
    logic [7:0] ops [2] = '{8'hA8, 8'h57};
    for (int o = 0; o < 2; o++)
      for (int b = 0; b < 8; b++)
        for (int c = 0; c < 2; c++) begin
          logic z; logic [7:0] v;
          v = ops[o]; z = ~v[b];
          issue(2'b01, 3'(b), v, 8'h77, {7'b0, c[0]}, 1'b0, 1'b0);
          chk("R8 test result", result, v);
          chk("R8 test flags Z H PV N C", {flg_out[6], flg_out[4], flg_out[2], flg_out[1], flg_out[0], 3'b0},
              {z, 1'b1, z, 1'b0, c[0], 3'b0});
          chk("R9 test S Y X", {flg_out[7], flg_out[5], flg_out[3], 5'b0},
              {(b == 7) && v[7], v[5], v[3], 5'b0});
        end
  endtask

  task automatic t_resset;
    for (int b = 0; b < 8; b++) begin
      issue(2'b10, 3'(b), 8'hFF, 8'h66, 8'h5A, 1'b0, 1'b0);
      chk("R10 res result", result, 8'hFF ^ (8'h01 << b));
      chk("R10 res flags", flg_out, 8'h5A);
      chk("R10 res acc", acc_out, 8'h66);
      issue(2'b11, 3'(b), 8'h00, 8'h66, 8'hA5, 1'b0, 1'b0);
      chk("R10 set result", result, 8'h01 << b);
      chk("R10 set flags", flg_out, 8'hA5);
    end
  endtask

  task automatic t_priority;
    issue(2'b11, 3'b000, 8'h9C, 8'h2B, 8'h00, 1'b1, 1'b1);
    chk("R11 nibble over fast", acc_out, 8'h29);
    chk("R11 nibble over fast mem", result, 8'hCB);
    issue(2'b11, 3'b001, 8'h00, 8'h02, 8'h00, 1'b1, 1'b0);
    chk("R11 fast over group", result, 8'h01);
    chk("R11 fast over group acc", acc_out, 8'h01);
  endtask

  initial begin
    #1;
    t_reset;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t_timing;
    t_rotates;
    t_shifts;
    t_fast;
    t_nibble;
    t_bittest;
    t_resset;
    t_priority;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule